// File: doc/BRIEF.md
# MDIO Management Master

This block is the master side of the two-wire PHY management bus. It produces the MDC clock, and it drives or releases the shared MDIO data line through an output-enable meant for an external tri-state pad. It runs Clause 22 register reads and writes. It also runs Clause 45 indirect accesses: an address frame that sets a 16-bit register pointer inside a device, then a read or write frame to that pointer.

A host sends one request with a start pulse. The request carries the operation, the PHY address, a 5-bit register/device field, a 16-bit register pointer and the write data. The block stays busy until the whole exchange is over. It then gives a one-cycle done pulse, the read data, and a flag that says whether the PHY failed to drive the turnaround bit low. All MDC timing is derived from the system clock. The low phase, the transmit high phase and the longer receive high phase are each set as a number of clock cycles. The receive high phase is longer so that slow PHYs have time to put data on the line.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC is low, MDIO output-enable is low, busy and done are low, the error flag is low and read data is zero.
- R2: Every frame starts with 32 driven '1' bits. The start field that follows is '01' for Clause 22 frames and '00' for Clause 45 frames.
- R3: The operation code is `reqOp` (00 Clause 22 read, 01 Clause 22 write, 10 Clause 45 read, 11 Clause 45 write). The Clause 22 read and write opcodes come from `c22RdOpcode` and `c22WrOpcode` (normally '10' and '01'). The Clause 45 opcodes are fixed: '00' for address, '01' for write, '11' for read.
- R4: After the opcode, the 5-bit PHY address and then the 5-bit register/device field are sent, each MSB first.
- R5: In write and address frames, the master drives '1','0' as turnaround, then 16 data bits MSB first. It then releases MDIO for exactly one more MDC clock.
- R6: In read frames, the master releases MDIO after the address fields and clocks one turnaround bit. If that bit is accepted, it shifts in 16 bits MSB first and clocks one extra bit. `rdData` holds the 16 bits when done pulses. MDIO is sampled when MDC falls.
- R7: If the turnaround bit reads '1' and the PHY's bit in `ignoreTaMask` is clear, the master clocks 32 more released bits, discards them, returns 0xFFFF and sets `taError`. If the mask bit is set, the read goes on as in R6.
- R8: A Clause 45 access is an address frame (device in the register field, `reqReg` as the data) followed at once by the read or write frame, with the same PHY and device fields.
- R9: Each MDC low phase lasts at least HALF_CYCLES clocks. A high phase lasts at least HALF_CYCLES while the master drives and at least RD_HIGH_CYCLES while MDIO is released. Driven data and the output-enable change only while MDC is low.
- R10: A start is accepted only when not busy, and a start while busy has no effect. busy stays high until done. done is a single-cycle pulse, one per accepted request.
- R11: `taError` holds its value until the next accepted start, which clears it.
- R12: While not busy, MDC is low and MDIO output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Request strobe, taken when idle |
| reqOp | input | 2 | Operation: bit1 Clause 45, bit0 write |
| reqPhy | input | 5 | PHY address |
| reqDev | input | 5 | Register (Clause 22) or device (Clause 45) field |
| reqReg | input | 16 | Clause 45 register pointer |
| reqWdata | input | 16 | Write data |
| c22RdOpcode | input | 2 | Clause 22 read opcode |
| c22WrOpcode | input | 2 | Clause 22 write opcode |
| ignoreTaMask | input | 32 | Per-PHY turnaround-check bypass |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Read result |
| taError | output | 1 | Turnaround failure on last read |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data to pad |
| mdioOe | output | 1 | Pad output-enable |
| mdioIn | input | 1 | Data from pad |

## Verification
The bench uses a PHY model that drives a scripted bit on each released rising MDC edge. Against that model it exercises: a turnaround bit of '1' with the mask bit clear and with it set; overridden Clause 22 opcodes; Clause 45 access pairs; and a start pulse given mid-frame. A design that skipped the mask would flag an error on a masked PHY. A design that mis-sized the flush would show the wrong number of released clocks. A design that leaked a busy-time start would send a second frame or raise an extra done. A design that put a wrong start or opcode field in the second Clause 45 frame would produce a mismatched transmitted bit string. The bench also measures each MDC phase to catch a read high phase that was not stretched, and checks that the error flag survives idle time and clears only on the next start.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    SEG_PRE,
    SEG_HDR,
    SEG_WTAIL,
    SEG_RX1,
    SEG_RX16,
    SEG_RX32
  } segKind_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH
  } bitPhase_t;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_PRE,
    CS_HDR,
    CS_WTAIL,
    CS_TA,
    CS_DATA,
    CS_FLUSH,
    CS_TAIL
  } ctrlState_t;

  typedef struct packed {
    logic     capture;
    logic     segGo;
    segKind_t kind;
    logic     addrPhase;
  } mdioStrobe_t;

  localparam int OPB_WRITE = 0;
  localparam int OPB_C45   = 1;

  localparam logic [1:0] C45_OP_ADDR  = 2'b00;
  localparam logic [1:0] C45_OP_WRITE = 2'b01;
  localparam logic [1:0] C45_OP_READ  = 2'b11;
  localparam logic [1:0] START_C22    = 2'b01;
  localparam logic [1:0] START_C45    = 2'b00;
  localparam logic [1:0] TA_DRIVEN    = 2'b10;

endpackage

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_CYCLES    = 32,
  parameter int unsigned RD_HIGH_CYCLES = 44,
  parameter int unsigned IN_SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrobe_t strobe,
  input  logic [1:0]  reqOp,
  input  logic [4:0]  reqPhy,
  input  logic [4:0]  reqDev,
  input  logic [15:0] reqReg,
  input  logic [15:0] reqWdata,
  input  logic [1:0]  c22RdOpcode,
  input  logic [1:0]  c22WrOpcode,
  input  logic        mdioIn,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic        segDone,
  output logic [15:0] rxWord,
  output logic [1:0]  reqOpQ,
  output logic [4:0]  reqPhyQ
);

  localparam int unsigned MAX_PHASE = (RD_HIGH_CYCLES > HALF_CYCLES) ? RD_HIGH_CYCLES : HALF_CYCLES;
  localparam int unsigned CNT_W     = $clog2(MAX_PHASE + 1);
  localparam logic [CNT_W-1:0] LOW_LAST   = CNT_W'(HALF_CYCLES - 1);
  localparam logic [CNT_W-1:0] TXHI_LAST  = CNT_W'(HALF_CYCLES - 1);
  localparam logic [CNT_W-1:0] RXHI_LAST  = CNT_W'(RD_HIGH_CYCLES - 1);

  // input synchroniser for the pad data
  logic mdioSync;
  generate
    if (IN_SYNC_STAGES == 0) begin : g_noSync
      assign mdioSync = mdioIn;
    end else begin : g_sync
      logic [IN_SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[IN_SYNC_STAGES-2+1-1:0], mdioIn} ;
      end
      assign mdioSync = syncQ[IN_SYNC_STAGES-1];
    end
  endgenerate

  // request capture
  logic [4:0]  devQ;
  logic [15:0] regQ;
  logic [15:0] wdataQ;
  logic [1:0]  rdOpQ;
  logic [1:0]  wrOpQ;
  logic        addrPhaseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqOpQ  <= '0;
      reqPhyQ <= '0;
      devQ    <= '0;
      regQ    <= '0;
      wdataQ  <= '0;
      rdOpQ   <= '0;
      wrOpQ   <= '0;
    end else if (strobe.capture) begin
      reqOpQ  <= reqOp;
      reqPhyQ <= reqPhy;
      devQ    <= reqDev;
      regQ    <= reqReg;
      wdataQ  <= reqWdata;
      rdOpQ   <= c22RdOpcode;
      wrOpQ   <= c22WrOpcode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             addrPhaseQ <= 1'b0;
    else if (strobe.segGo) addrPhaseQ <= strobe.addrPhase;
  end

  // segment word builder (left aligned, MSB leaves first)
  logic        isC45;
  logic        isWrite;
  logic [1:0]  startField;
  logic [1:0]  opField;
  logic [15:0] tailData;
  logic [31:0] segWord;
  logic [5:0]  segLen;
  logic        segTx;

  assign isC45   = reqOpQ[OPB_C45];
  assign isWrite = reqOpQ[OPB_WRITE];

  always_comb begin
    startField = isC45 ? START_C45 : START_C22;
    if (strobe.addrPhase)  opField = C45_OP_ADDR;
    else if (isC45)        opField = isWrite ? C45_OP_WRITE : C45_OP_READ;
    else                   opField = isWrite ? wrOpQ : rdOpQ;
    tailData = strobe.addrPhase ? regQ : wdataQ;
    segWord  = '1;
    segLen   = 6'd1;
    segTx    = 1'b0;
    case (strobe.kind)
      SEG_PRE: begin
        segWord = '1;
        segLen  = 6'd32;
        segTx   = 1'b1;
      end
      SEG_HDR: begin
        segWord = {startField, opField, reqPhyQ, devQ, 18'd0};
        segLen  = 6'd14;
        segTx   = 1'b1;
      end
      SEG_WTAIL: begin
        segWord = {TA_DRIVEN, tailData, 14'd0};
        segLen  = 6'd18;
        segTx   = 1'b1;
      end
      SEG_RX1:  segLen = 6'd1;
      SEG_RX16: segLen = 6'd16;
      SEG_RX32: segLen = 6'd32;
      default:  segLen = 6'd1;
    endcase
  end

  // bit engine
  bitPhase_t        phase;
  logic [CNT_W-1:0] phaseCnt;
  logic [5:0]       bitsLeft;
  logic             txMode;
  logic [31:0]      txShift;
  logic [CNT_W-1:0] highLast;

  assign highLast = txMode ? TXHI_LAST : RXHI_LAST;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      phaseCnt <= '0;
      bitsLeft <= '0;
      txMode   <= 1'b0;
      txShift  <= '0;
      mdc      <= 1'b0;
      mdioOut  <= 1'b0;
      mdioOe   <= 1'b0;
      rxWord   <= '0;
      segDone  <= 1'b0;
    end else begin
      segDone <= 1'b0;
      if (strobe.segGo) begin
        phase    <= PH_LOW;
        phaseCnt <= '0;
        bitsLeft <= segLen;
        txMode   <= segTx;
        mdioOe   <= segTx;
        mdioOut  <= segWord[31];
        txShift  <= {segWord[30:0], 1'b0};
      end else begin
        case (phase)
          PH_LOW: begin
            if (phaseCnt == LOW_LAST) begin
              mdc      <= 1'b1;
              phase    <= PH_HIGH;
              phaseCnt <= '0;
            end else begin
              phaseCnt <= phaseCnt + 1'b1;
            end
          end
          PH_HIGH: begin
            if (phaseCnt == highLast) begin
              mdc      <= 1'b0;
              phaseCnt <= '0;
              if (!txMode) rxWord <= {rxWord[14:0], mdioSync};
              if (bitsLeft == 6'd1) begin
                phase   <= PH_IDLE;
                segDone <= 1'b1;
              end else begin
                phase    <= PH_LOW;
                bitsLeft <= bitsLeft - 1'b1;
                mdioOut  <= txShift[31];
                txShift  <= {txShift[30:0], 1'b0};
              end
            end else begin
              phaseCnt <= phaseCnt + 1'b1;
            end
          end
          default: phaseCnt <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqStart,
  input  logic [1:0]  reqOp,
  input  logic [31:0] ignoreTaMask,
  input  logic        segDone,
  input  logic [15:0] rxWord,
  input  logic [1:0]  reqOpQ,
  input  logic [4:0]  reqPhyQ,
  output mdioStrobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        taError
);

  ctrlState_t state, stateNxt;
  logic       addrPhase, addrPhaseNxt;
  logic       finish, loadRd, setErr;
  logic       taBad;

  assign taBad = rxWord[0] && !ignoreTaMask[reqPhyQ];
  assign busy  = (state != CS_IDLE);

  always_comb begin
    stateNxt     = state;
    addrPhaseNxt = addrPhase;
    finish       = 1'b0;
    loadRd       = 1'b0;
    setErr       = 1'b0;
    strobe       = '{capture: 1'b0, segGo: 1'b0, kind: SEG_PRE, addrPhase: 1'b0};
    case (state)
      CS_IDLE: begin
        if (reqStart) begin
          strobe.capture = 1'b1;
          strobe.segGo   = 1'b1;
          strobe.kind    = SEG_PRE;
          addrPhaseNxt   = reqOp[OPB_C45];
          stateNxt       = CS_PRE;
        end
      end
      CS_PRE: if (segDone) begin
        strobe.segGo = 1'b1;
        strobe.kind  = SEG_HDR;
        stateNxt     = CS_HDR;
      end
      CS_HDR: if (segDone) begin
        strobe.segGo = 1'b1;
        if (addrPhase || reqOpQ[OPB_WRITE]) begin
          strobe.kind = SEG_WTAIL;
          stateNxt    = CS_WTAIL;
        end else begin
          strobe.kind = SEG_RX1;
          stateNxt    = CS_TA;
        end
      end
      CS_WTAIL: if (segDone) begin
        strobe.segGo = 1'b1;
        strobe.kind  = SEG_RX1;
        stateNxt     = CS_TAIL;
      end
      CS_TA: if (segDone) begin
        strobe.segGo = 1'b1;
        if (taBad) begin
          strobe.kind = SEG_RX32;
          stateNxt    = CS_FLUSH;
        end else begin
          strobe.kind = SEG_RX16;
          stateNxt    = CS_DATA;
        end
      end
      CS_DATA: if (segDone) begin
        loadRd       = 1'b1;
        strobe.segGo = 1'b1;
        strobe.kind  = SEG_RX1;
        stateNxt     = CS_TAIL;
      end
      CS_FLUSH: if (segDone) begin
        setErr   = 1'b1;
        finish   = 1'b1;
        stateNxt = CS_IDLE;
      end
      CS_TAIL: if (segDone) begin
        if (addrPhase) begin
          addrPhaseNxt = 1'b0;
          strobe.segGo = 1'b1;
          strobe.kind  = SEG_PRE;
          stateNxt     = CS_PRE;
        end else begin
          finish   = 1'b1;
          stateNxt = CS_IDLE;
        end
      end
      default: stateNxt = CS_IDLE;
    endcase
    strobe.addrPhase = addrPhaseNxt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= CS_IDLE;
      addrPhase <= 1'b0;
      done      <= 1'b0;
      rdData    <= '0;
      taError   <= 1'b0;
    end else begin
      state     <= stateNxt;
      addrPhase <= addrPhaseNxt;
      done      <= finish;
      if (strobe.capture) taError <= 1'b0;
      if (loadRd)         rdData  <= rxWord;
      if (setErr) begin
        rdData  <= 16'hFFFF;
        taError <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_CYCLES    = 32,
  parameter int unsigned RD_HIGH_CYCLES = 44,
  parameter int unsigned IN_SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqStart,
  input  logic [1:0]  reqOp,
  input  logic [4:0]  reqPhy,
  input  logic [4:0]  reqDev,
  input  logic [15:0] reqReg,
  input  logic [15:0] reqWdata,
  input  logic [1:0]  c22RdOpcode,
  input  logic [1:0]  c22WrOpcode,
  input  logic [31:0] ignoreTaMask,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        taError,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  mdioStrobe_t strobe;
  logic        segDone;
  logic [15:0] rxWord;
  logic [1:0]  reqOpQ;
  logic [4:0]  reqPhyQ;

  mdio_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqStart     (reqStart),
    .reqOp        (reqOp),
    .ignoreTaMask (ignoreTaMask),
    .segDone      (segDone),
    .rxWord       (rxWord),
    .reqOpQ       (reqOpQ),
    .reqPhyQ      (reqPhyQ),
    .strobe       (strobe),
    .busy         (busy),
    .done         (done),
    .rdData       (rdData),
    .taError      (taError)
  );

  mdio_datapath #(
    .HALF_CYCLES    (HALF_CYCLES),
    .RD_HIGH_CYCLES (RD_HIGH_CYCLES),
    .IN_SYNC_STAGES (IN_SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqOp       (reqOp),
    .reqPhy      (reqPhy),
    .reqDev      (reqDev),
    .reqReg      (reqReg),
    .reqWdata    (reqWdata),
    .c22RdOpcode (c22RdOpcode),
    .c22WrOpcode (c22WrOpcode),
    .mdioIn      (mdioIn),
    .mdc         (mdc),
    .mdioOut     (mdioOut),
    .mdioOe      (mdioOe),
    .segDone     (segDone),
    .rxWord      (rxWord),
    .reqOpQ      (reqOpQ),
    .reqPhyQ     (reqPhyQ)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned HALF_CYCLES    = 32,
  parameter int unsigned RD_HIGH_CYCLES = 44
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqStart,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdData,
  input logic        taError,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe
);

  logic [15:0] lowCnt;
  logic [15:0] highCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= '0;
    end else begin
      if (mdc) begin
        lowCnt  <= '0;
        highCnt <= (highCnt == 16'hFFFF) ? highCnt : highCnt + 16'd1;
      end else begin
        highCnt <= '0;
        lowCnt  <= (lowCnt == 16'hFFFF) ? lowCnt : lowCnt + 16'd1;
      end
    end
  end

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_ta_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(taError) |-> (done && rdData == 16'hFFFF));

  assert_err_clear_on_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(taError) |-> ($past(reqStart) && !$past(busy)));

  assert_oe_change_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    $changed(mdioOe) |-> !mdc);

  assert_data_hold_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc) && mdioOe) |-> $stable(mdioOut));

  assert_low_phase_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> (lowCnt >= 16'(HALF_CYCLES)));

  assert_tx_high_phase_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mdc) && mdioOe) |-> (highCnt >= 16'(HALF_CYCLES)));

  assert_rx_high_phase_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mdc) && !mdioOe) |-> (highCnt >= 16'(RD_HIGH_CYCLES)));

endmodule

bind mdio_master mdio_master_chk #(
  .HALF_CYCLES    (HALF_CYCLES),
  .RD_HIGH_CYCLES (RD_HIGH_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqStart (reqStart),
  .busy     (busy),
  .done     (done),
  .rdData   (rdData),
  .taError  (taError),
  .mdc      (mdc),
  .mdioOut  (mdioOut),
  .mdioOe   (mdioOe)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;

  localparam int HALF = 4;
  localparam int RDH  = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqStart = 1'b0;
  logic [1:0]  reqOp = '0;
  logic [4:0]  reqPhy = '0;
  logic [4:0]  reqDev = '0;
  logic [15:0] reqReg = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  c22RdOpcode = 2'b10;
  logic [1:0]  c22WrOpcode = 2'b01;
  logic [31:0] ignoreTaMask = 32'h0000_0100;
  logic        busy, done, taError, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;
  logic        phyBit = 1'b1;

  always #4 clk = ~clk;

  mdio_master #(.HALF_CYCLES(HALF), .RD_HIGH_CYCLES(RDH), .IN_SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqOp(reqOp), .reqPhy(reqPhy),
    .reqDev(reqDev), .reqReg(reqReg), .reqWdata(reqWdata), .c22RdOpcode(c22RdOpcode),
    .c22WrOpcode(c22WrOpcode), .ignoreTaMask(ignoreTaMask), .busy(busy), .done(done),
    .rdData(rdData), .taError(taError), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(phyBit)
  );

  typedef struct {
    int           txLen;
    logic [255:0] txBits;
    int           rxClk;
    logic [15:0]  rd;
    logic         err;
    bit           isRead;
  } exp_t;

  exp_t         expQ[$];
  bit           rxScript[$];
  int           nChecks = 0;
  int           nFails  = 0;
  logic [255:0] capTx;
  int           capTxN = 0;
  int           capRxN = 0;
  logic [255:0] bBits;
  int           bN;
  int           bRx;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic addBits(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      bBits[bN] = v[i];
      bN++;
    end
  endtask

  // PHY model: capture driven bits, drive scripted bits on released clocks
  always begin
    @(posedge mdc);
    #1;
    if (mdioOe) begin
      if (capTxN < 256) capTx[capTxN] = mdioOut;
      capTxN++;
    end else begin
      capRxN++;
      if (rxScript.size() > 0) phyBit = rxScript.pop_front();
      else                     phyBit = 1'b1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected done", 256'd1, 256'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(capTxN == e.txLen, "R2 R5 R8", "driven bit count", 256'(capTxN), 256'(e.txLen));
        check(capTx == e.txBits, "R2 R3 R4 R5 R8", "driven bit string", capTx, e.txBits);
        check(capRxN == e.rxClk, "R6 R7", "released clock count", 256'(capRxN), 256'(e.rxClk));
        if (e.isRead)
          check(rdData == e.rd, "R6 R7", "read data", 256'(rdData), 256'(e.rd));
        check(taError == e.err, "R7", "turnaround flag", 256'(taError), 256'(e.err));
        check(!mdc && !mdioOe, "R12", "bus quiet at done", {mdc, mdioOe}, 256'd0);
      end
    end
  end

  // MDC phase measurement
  int  lowRun = 0, highRun = 0;
  int  minLow = 1000, minHighTx = 1000, minHighRx = 1000;
  int  holdViol = 0;
  logic prevMdc = 1'b0, prevOut = 1'b0, prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (mdc && prevMdc && mdioOe && (mdioOut != prevOut)) holdViol++;
      if (mdc && (mdioOe != prevOe)) holdViol++;
      if (mdc) begin
        if (!prevMdc && lowRun < minLow) minLow = lowRun;
        highRun++;
        lowRun = 0;
      end else begin
        if (prevMdc) begin
          if (mdioOe && highRun < minHighTx)  minHighTx = highRun;
          if (!mdioOe && highRun < minHighRx) minHighRx = highRun;
        end
        lowRun++;
        highRun = 0;
      end
    end
    prevMdc = mdc;
    prevOut = mdioOut;
    prevOe  = mdioOe;
  end

  task automatic doXfer(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] dev,
                        input logic [15:0] regp, input logic [15:0] wdata,
                        input bit taBit, input logic [15:0] phyVal, input bit poke);
    exp_t e;
    bit   c45 = op[1];
    bit   wr  = op[0];
    bN = 0; bBits = '0; bRx = 0;
    rxScript.delete();
    if (c45) begin
      addBits(32'hFFFF_FFFF, 32); addBits(2'b00, 2); addBits(2'b00, 2);
      addBits(phy, 5); addBits(dev, 5); addBits(2'b10, 2); addBits(regp, 16);
      rxScript.push_back(1'b1); bRx++;
    end
    addBits(32'hFFFF_FFFF, 32);
    addBits(c45 ? 2'b00 : 2'b01, 2);
    if (c45) addBits(wr ? 2'b01 : 2'b11, 2);
    else     addBits(wr ? c22WrOpcode : c22RdOpcode, 2);
    addBits(phy, 5); addBits(dev, 5);
    e.isRead = !wr;
    e.err    = 1'b0;
    e.rd     = 16'h0;
    if (wr) begin
      addBits(2'b10, 2); addBits(wdata, 16);
      rxScript.push_back(1'b1); bRx++;
    end else begin
      rxScript.push_back(taBit); bRx++;
      if (taBit && !ignoreTaMask[phy]) begin
        for (int i = 0; i < 32; i++) rxScript.push_back(1'b0);
        bRx += 32;
        e.rd = 16'hFFFF; e.err = 1'b1;
      end else begin
        for (int i = 15; i >= 0; i--) rxScript.push_back(phyVal[i]);
        rxScript.push_back(1'b1);
        bRx += 17;
        e.rd = phyVal;
      end
    end
    e.txLen = bN; e.txBits = bBits; e.rxClk = bRx;
    expQ.push_back(e);
    capTx = '0; capTxN = 0; capRxN = 0;
    @(negedge clk);
    reqOp = op; reqPhy = phy; reqDev = dev; reqReg = regp; reqWdata = wdata;
    reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", 256'(busy), 256'd1);
    check(taError == 1'b0, "R11", "flag cleared by start", 256'(taError), 256'd0);
    if (poke) begin
      repeat (100) @(negedge clk);
      reqOp = ~op; reqPhy = ~phy; reqDev = ~dev; reqReg = ~regp; reqWdata = ~wdata;
      reqStart = 1'b1;
      @(negedge clk);
      reqStart = 1'b0;
      check(busy == 1'b1, "R10", "busy held over ignored start", 256'(busy), 256'd1);
    end
    do @(negedge clk); while (!done);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 256'd0, 256'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!mdc && !mdioOe && !busy && !done && !taError && rdData == 16'h0,
          "R1", "reset state", {mdc, mdioOe, busy, done, taError, rdData}, 256'd0);

    doXfer(2'b01, 5'd5, 5'h1A, 16'h0, 16'hA5C3, 1'b0, 16'h0, 1'b0);       // C22 write
    doXfer(2'b00, 5'd3, 5'h02, 16'h0, 16'h0, 1'b0, 16'h1234, 1'b0);       // C22 read
    doXfer(2'b00, 5'd17, 5'h04, 16'h0, 16'h0, 1'b1, 16'h0, 1'b0);         // TA fail
    repeat (30) @(negedge clk);
    check(taError == 1'b1 && rdData == 16'hFFFF, "R11", "flag held while idle",
          {taError, rdData}, {1'b1, 16'hFFFF});
    c22RdOpcode = 2'b11; c22WrOpcode = 2'b00;                               // R3 override
    doXfer(2'b01, 5'd9, 5'h10, 16'h0, 16'h8001, 1'b0, 16'h0, 1'b0);
    doXfer(2'b00, 5'd9, 5'h11, 16'h0, 16'h0, 1'b0, 16'h6C39, 1'b0);
    c22RdOpcode = 2'b10; c22WrOpcode = 2'b01;
    doXfer(2'b00, 5'd8, 5'h05, 16'h0, 16'h0, 1'b1, 16'hBEEF, 1'b0);       // masked PHY, R7
    doXfer(2'b11, 5'h1F, 5'h07, 16'h8001, 16'h0F0F, 1'b0, 16'h0, 1'b1);   // C45 write + poke
    doXfer(2'b10, 5'd2, 5'h01, 16'hC0DE, 16'h0, 1'b0, 16'h5A5A, 1'b0);    // C45 read
    doXfer(2'b10, 5'd4, 5'h03, 16'h0042, 16'h0, 1'b1, 16'h0, 1'b0);       // C45 TA fail
    doXfer(2'b00, 5'd0, 5'h00, 16'h0, 16'h0, 1'b0, 16'h0001, 1'b0);

    repeat (60) @(negedge clk);
    check(expQ.size() == 0 && !busy, "R10", "no pending or extra transfer",
          256'(expQ.size()), 256'd0);
    check(minLow >= HALF, "R9", "shortest MDC low", 256'(minLow), 256'(HALF));
    check(minHighTx >= HALF, "R9", "shortest driven MDC high", 256'(minHighTx), 256'(HALF));
    check(minHighRx >= RDH, "R9", "shortest released MDC high", 256'(minHighRx), 256'(RDH));
    check(holdViol == 0, "R9", "data or enable moved while MDC high", 256'(holdViol), 256'd0);
    check(!mdc && !mdioOe, "R12", "idle bus", {mdc, mdioOe}, 256'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule